// File: doc/BRIEF.md
# Two-Stage Lockable Watchdog Timer

This block is a watchdog peripheral on a simple byte-addressed register bus. Software loads two preload values, picks a prescaler and an action on expiry, and then enables counting. The counter first runs down through stage one; when that stage runs out it raises a one-cycle interrupt pulse and reloads itself from the second preload. When stage two also runs out, the block records a sticky timeout flag. It then issues a one-cycle system reset pulse on a warm or cold reset line, holds a timeout output, or does both, depending on the configuration.

Software refreshes the watchdog with a reload command. The reload command, the flag clear and both preload registers are guarded: each such write must be preceded by a two-byte key written to the key register. A lock bit freezes the configuration, the preloads and the lock register itself until power-on reset. The timeout flag lives in the power-on domain, so it survives the system reset that the watchdog itself causes and can be read afterwards.

The bus is a plain write strobe with a combinational read port. Every access is accepted in the cycle it is presented, so there is no back-pressure.

Top module: `wdog_core`

## Requirements
- R1: After power-on reset, every output is low and the preloads, configuration, lock register, down counter and timeout flag all read as zero.
- R2: A guarded write (preload 1 at 0x00, preload 2 at 0x04, command at 0x0D) takes effect only when the bytes 0x80 and then 0x86 were written to the key register at 0x0C before it. Without that key, the write is ignored.
- R3: One key covers exactly one guarded write, whether or not that write takes effect. Any other byte written to 0x0C between 0x80 and 0x86 cancels the partial key.
- R4: A keyed write with command bit 0 set restarts the count: it loads preload 1 into the counter, returns to stage one and clears the prescaler.
- R5: Configuration bit 2 (register 0x10) selects the tick period: 0 gives 2^SHORT_LOG2 clocks per tick and 1 gives 2^LONG_LOG2 clocks per tick. The first tick falls one full period after a restart.
- R6: Stage one lasts preload 1 plus one ticks. At its end, irq_o pulses for one cycle and the counter loads preload 2.
- R7: Stage two lasts preload 2 plus one ticks. At its end the timeout flag (bit 1 of 0x0D) is set. If configuration bit 4 is set, a one-cycle pulse appears on rst_cold_o when bit 3 is 1 and on rst_warm_o when bit 3 is 0. If configuration bit 5 is set, timeout_o goes high and stays high until the next restart.
- R8: The timeout flag is unaffected by sys_rst_n. It is cleared by power-on reset, or by a keyed write to 0x0D with bit 1 set.
- R9: Once lock bit 0 of 0x18 is written as 1, writes to the configuration, to the preloads and to 0x18 are ignored until power-on reset. The keyed reload command still works.
- R10: Bit 1 of 0x18 starts counting (from preload 1, stage one) when written as 1 and freezes the counter when written as 0. sys_rst_n clears this bit.
- R11: Bit 2 of 0x18 selects what follows expiry: 1 restarts stage one from preload 1, and 0 parks the counter at zero until a restart.
- R12: Reading 0x14 returns the current down-counter value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, synchronous; clears everything |
| sys_rst_n | input | 1 | System reset, active low, synchronous; spares flag, lock, preloads and configuration |
| bus_addr | input | 8 | Byte address for reads and writes |
| bus_wr | input | 1 | Write strobe, accepted in the cycle it is high |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_o | output | 1 | One-cycle pulse at the end of stage one |
| rst_warm_o | output | 1 | One-cycle warm reset request |
| rst_cold_o | output | 1 | One-cycle cold reset request |
| timeout_o | output | 1 | Timeout level, held from expiry until restart |

## Verification
The bench counts clock edges from a keyed restart to the interrupt and to expiry, over random preloads and both tick periods. A design that is off by one tick in either stage, or that fails to clear the prescaler on restart, lands on the wrong edge. It checks that a key is spent by one guarded write and that a stray byte breaks a partial key; a key that stays valid would let the second unkeyed preload write through. It also checks that the flag survives sys_rst_n but not power-on reset, that a lock blocks configuration while still allowing reload, and that the counter reads preload 1 or zero right after expiry, depending on the restart mode.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam logic [7:0] OFS_PL1  = 8'h00;
  localparam logic [7:0] OFS_PL2  = 8'h04;
  localparam logic [7:0] OFS_KEY  = 8'h0C;
  localparam logic [7:0] OFS_CMD  = 8'h0D;
  localparam logic [7:0] OFS_CFG  = 8'h10;
  localparam logic [7:0] OFS_CNT  = 8'h14;
  localparam logic [7:0] OFS_LOCK = 8'h18;

  localparam logic [7:0] KEY_FIRST  = 8'h80;
  localparam logic [7:0] KEY_SECOND = 8'h86;

  localparam int CMD_RELOAD = 0;
  localparam int CMD_FLAG   = 1;
  localparam int CFG_LONG   = 2;
  localparam int CFG_COLD   = 3;
  localparam int CFG_RSTEN  = 4;
  localparam int CFG_TOEN   = 5;
  localparam int LK_LOCK    = 0;
  localparam int LK_RUN     = 1;
  localparam int LK_LOOP    = 2;

  typedef enum logic [1:0] { K_IDLE, K_HALF, K_ARMED } key_st_e;
  typedef enum logic [1:0] { ST_ONE, ST_TWO, ST_DONE } stage_e;
endpackage

// File: rtl/wdog_keygate.sv
module wdog_keygate
  import wdog_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       key_wr,
  input  logic [7:0] key_byte,
  input  logic       prot_wr,
  output logic       armed_o
);
  key_st_e st_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= K_IDLE;
    end else if (key_wr) begin
      if (key_byte == KEY_FIRST)
        st_q <= K_HALF;
      else if (key_byte == KEY_SECOND && st_q == K_HALF)
        st_q <= K_ARMED;
      else
        st_q <= K_IDLE;
    end else if (prot_wr) begin
      st_q <= K_IDLE;
    end
  end

  assign armed_o = (st_q == K_ARMED);
endmodule

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
  parameter int SHORT_LOG2 = 5,
  parameter int LONG_LOG2  = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clear,
  input  logic sel_long,
  output logic tick
);
  localparam int PW = (LONG_LOG2 > SHORT_LOG2) ? LONG_LOG2 : SHORT_LOG2;
  localparam logic [PW-1:0] MAX_S = PW'((64'd1 << SHORT_LOG2) - 64'd1);
  localparam logic [PW-1:0] MAX_L = PW'((64'd1 << LONG_LOG2) - 64'd1);

  logic [PW-1:0] pre_q;
  logic [PW-1:0] limit;

  assign limit = sel_long ? MAX_L : MAX_S;
  assign tick  = run && !clear && (pre_q >= limit);

  always_ff @(posedge clk) begin
    if (!rst_n || clear)
      pre_q <= '0;
    else if (run)
      pre_q <= (pre_q >= limit) ? '0 : pre_q + PW'(1);
  end
endmodule

// File: rtl/wdog_stages.sv
module wdog_stages
  import wdog_pkg::*;
#(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic             loop_mode,
  input  logic [CNT_W-1:0] pre1,
  input  logic [CNT_W-1:0] pre2,
  output logic [CNT_W-1:0] count_o,
  output stage_e           stage_o,
  output logic             end1_o,
  output logic             end2_o
);
  logic [CNT_W-1:0] cnt_q;
  stage_e           st_q;
  logic             at_zero;

  assign at_zero = (cnt_q == '0);
  assign end1_o  = !load && tick && st_q == ST_ONE && at_zero;
  assign end2_o  = !load && tick && st_q == ST_TWO && at_zero;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      st_q  <= ST_ONE;
    end else if (load) begin
      cnt_q <= pre1;
      st_q  <= ST_ONE;
    end else if (tick) begin
      unique case (st_q)
        ST_ONE: begin
          if (at_zero) begin
            cnt_q <= pre2;
            st_q  <= ST_TWO;
          end else begin
            cnt_q <= cnt_q - CNT_W'(1);
          end
        end
        ST_TWO: begin
          if (at_zero) begin
            cnt_q <= loop_mode ? pre1 : '0;
            st_q  <= loop_mode ? ST_ONE : ST_DONE;
          end else begin
            cnt_q <= cnt_q - CNT_W'(1);
          end
        end
        default: begin
          cnt_q <= cnt_q;
        end
      endcase
    end
  end

  assign count_o = cnt_q;
  assign stage_o = st_q;
endmodule

// File: rtl/wdog_core.sv
module wdog_core
  import wdog_pkg::*;
#(
  parameter int CNT_W      = 20,
  parameter int SHORT_LOG2 = 5,
  parameter int LONG_LOG2  = 15
) (
  input  logic        clk,
  input  logic        por_n,
  input  logic        sys_rst_n,
  input  logic [7:0]  bus_addr,
  input  logic        bus_wr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq_o,
  output logic        rst_warm_o,
  output logic        rst_cold_o,
  output logic        timeout_o
);
  localparam int DW  = 32;
  localparam int PAD = DW - CNT_W;

  logic rst_sys_n;
  assign rst_sys_n = por_n && sys_rst_n;

  // address decode
  logic wr_key, wr_pl1, wr_pl2, wr_cmd, wr_cfg, wr_lock, prot_wr;
  assign wr_key  = bus_wr && bus_addr == OFS_KEY;
  assign wr_pl1  = bus_wr && bus_addr == OFS_PL1;
  assign wr_pl2  = bus_wr && bus_addr == OFS_PL2;
  assign wr_cmd  = bus_wr && bus_addr == OFS_CMD;
  assign wr_cfg  = bus_wr && bus_addr == OFS_CFG;
  assign wr_lock = bus_wr && bus_addr == OFS_LOCK;
  assign prot_wr = wr_pl1 || wr_pl2 || wr_cmd;

  logic armed;
  wdog_keygate u_key (
    .clk      (clk),
    .rst_n    (rst_sys_n),
    .key_wr   (wr_key),
    .key_byte (bus_wdata[7:0]),
    .prot_wr  (prot_wr),
    .armed_o  (armed)
  );

  // power-on domain state
  logic [CNT_W-1:0] pl1_q, pl2_q;
  logic             cfg_long_q, cfg_cold_q, cfg_rsten_q, cfg_toen_q;
  logic             lock_q, loop_q, flag_q;
  // system domain state
  logic             run_q, hold_q;

  logic reload_cmd, flag_clr, run_start, load_any;
  logic end1, end2;

  assign reload_cmd = wr_cmd && armed && bus_wdata[CMD_RELOAD];
  assign flag_clr   = wr_cmd && armed && bus_wdata[CMD_FLAG];
  assign run_start  = wr_lock && !lock_q && bus_wdata[LK_RUN] && !run_q;
  assign load_any   = reload_cmd || run_start;

  always_ff @(posedge clk) begin
    if (!por_n) begin
      pl1_q       <= '0;
      pl2_q       <= '0;
      cfg_long_q  <= 1'b0;
      cfg_cold_q  <= 1'b0;
      cfg_rsten_q <= 1'b0;
      cfg_toen_q  <= 1'b0;
      lock_q      <= 1'b0;
      loop_q      <= 1'b0;
    end else begin
      if (wr_pl1 && armed && !lock_q) pl1_q <= bus_wdata[CNT_W-1:0];
      if (wr_pl2 && armed && !lock_q) pl2_q <= bus_wdata[CNT_W-1:0];
      if (wr_cfg && !lock_q) begin
        cfg_long_q  <= bus_wdata[CFG_LONG];
        cfg_cold_q  <= bus_wdata[CFG_COLD];
        cfg_rsten_q <= bus_wdata[CFG_RSTEN];
        cfg_toen_q  <= bus_wdata[CFG_TOEN];
      end
      if (wr_lock && !lock_q) begin
        lock_q <= bus_wdata[LK_LOCK];
        loop_q <= bus_wdata[LK_LOOP];
      end
    end
  end

  // sticky flag: set wins over clear, spared by system reset
  always_ff @(posedge clk) begin
    if (!por_n)
      flag_q <= 1'b0;
    else if (end2)
      flag_q <= 1'b1;
    else if (flag_clr)
      flag_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_sys_n)
      run_q <= 1'b0;
    else if (wr_lock && !lock_q)
      run_q <= bus_wdata[LK_RUN];
  end

  logic tick;
  wdog_prescale #(
    .SHORT_LOG2 (SHORT_LOG2),
    .LONG_LOG2  (LONG_LOG2)
  ) u_pre (
    .clk      (clk),
    .rst_n    (rst_sys_n),
    .run      (run_q),
    .clear    (load_any),
    .sel_long (cfg_long_q),
    .tick     (tick)
  );

  logic [CNT_W-1:0] count;
  stage_e           stage;
  wdog_stages #(
    .CNT_W (CNT_W)
  ) u_stg (
    .clk       (clk),
    .rst_n     (rst_sys_n),
    .tick      (tick),
    .load      (load_any),
    .loop_mode (loop_q),
    .pre1      (pl1_q),
    .pre2      (pl2_q),
    .count_o   (count),
    .stage_o   (stage),
    .end1_o    (end1),
    .end2_o    (end2)
  );

  // registered event outputs
  always_ff @(posedge clk) begin
    if (!rst_sys_n) begin
      irq_o      <= 1'b0;
      rst_warm_o <= 1'b0;
      rst_cold_o <= 1'b0;
      hold_q     <= 1'b0;
    end else begin
      irq_o      <= end1;
      rst_warm_o <= end2 && cfg_rsten_q && !cfg_cold_q;
      rst_cold_o <= end2 && cfg_rsten_q && cfg_cold_q;
      if (end2)
        hold_q <= 1'b1;
      else if (load_any)
        hold_q <= 1'b0;
    end
  end

  assign timeout_o = hold_q && cfg_toen_q;

  // read port
  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      OFS_PL1:  bus_rdata = {{PAD{1'b0}}, pl1_q};
      OFS_PL2:  bus_rdata = {{PAD{1'b0}}, pl2_q};
      OFS_CMD:  bus_rdata = {30'd0, flag_q, 1'b0};
      OFS_CFG:  bus_rdata = {26'd0, cfg_toen_q, cfg_rsten_q, cfg_cold_q, cfg_long_q, 2'b00};
      OFS_CNT:  bus_rdata = {{PAD{1'b0}}, count};
      OFS_LOCK: bus_rdata = {29'd0, loop_q, run_q, lock_q};
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/wdog_chk.sv
module wdog_chk
  import wdog_pkg::*;
#(
  parameter int CNT_W = 20
) (
  input logic             clk,
  input logic             por_n,
  input logic             sys_rst_n,
  input logic             irq_o,
  input logic             rst_warm_o,
  input logic             rst_cold_o,
  input logic             flag_q,
  input logic             lock_q,
  input logic             run_q,
  input logic             load_any,
  input stage_e           stage,
  input logic [CNT_W-1:0] count
);
  // R6: the stage-one pulse leaves the block in stage two
  a_r6_irq_enters_stage2: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
    irq_o |-> stage == ST_TWO);

  // R7: a reset request implies the flag is recorded
  a_r7_reset_sets_flag: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
    (rst_warm_o || rst_cold_o) |-> flag_q);

  // R7: reset requests are single-cycle and never both kinds
  a_r7_pulse_single: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
    (rst_warm_o || rst_cold_o) |=> !(rst_warm_o || rst_cold_o));

  a_r7_one_kind: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
    !(rst_warm_o && rst_cold_o));

  // R9: the lock holds until power-on reset
  a_r9_lock_sticks: assert property (@(posedge clk) disable iff (!por_n)
    lock_q |=> lock_q);

  // R10: a stopped counter does not move
  a_r10_frozen: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
    (!run_q && !load_any) |=> $stable(count));
endmodule

bind wdog_core wdog_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .por_n      (por_n),
  .sys_rst_n  (sys_rst_n),
  .irq_o      (irq_o),
  .rst_warm_o (rst_warm_o),
  .rst_cold_o (rst_cold_o),
  .flag_q     (flag_q),
  .lock_q     (lock_q),
  .run_q      (run_q),
  .load_any   (load_any),
  .stage      (stage),
  .count      (count)
);

// File: tb/wdog_core_tb_top.sv
module wdog_core_tb_top;
  localparam int SH = 2;
  localparam int LG = 4;

  logic        clk = 1'b0;
  logic        por_n = 1'b0;
  logic        sys_rst_n = 1'b1;
  logic [7:0]  bus_addr = 8'h00;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic        irq_o, rst_warm_o, rst_cold_o, timeout_o;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  wdog_core #(.CNT_W(20), .SHORT_LOG2(SH), .LONG_LOG2(LG)) dut_i (
    .clk        (clk),
    .por_n      (por_n),
    .sys_rst_n  (sys_rst_n),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .irq_o      (irq_o),
    .rst_warm_o (rst_warm_o),
    .rst_cold_o (rst_cold_o),
    .timeout_o  (timeout_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic unlock();
    wr(8'h0C, 32'h80);
    wr(8'h0C, 32'h86);
  endtask

  task automatic power_on();
    @(negedge clk); por_n = 1'b0;
    repeat (2) @(negedge clk);
    por_n = 1'b1;
  endtask

  function automatic int edges_for(input int ticks, input bit lng);
    return ticks << (lng ? LG : SH);
  endfunction

  task automatic run_case(input int p1, input int p2, input bit lng, input bit cold,
                          input bit rsten, input bit toen, input bit loop, input bit keep);
    int e1, e2, irq_at, exp_at;
    logic cold_s, warm_s, to_s;
    logic [31:0] cnt_s, r;
    e1 = edges_for(p1 + 1, lng);
    e2 = edges_for(p1 + p2 + 2, lng);
    irq_at = -1; exp_at = -1;
    cold_s = 0; warm_s = 0; to_s = 0; cnt_s = '0;
    unlock(); wr(8'h00, p1);
    unlock(); wr(8'h04, p2);
    wr(8'h10, {26'd0, toen, rsten, cold, lng, 2'b00});
    wr(8'h18, {29'd0, loop, 1'b1, 1'b0});
    unlock(); wr(8'h0D, 32'h1);
    bus_addr = 8'h14;
    for (int n = 1; n <= e2 + 4; n++) begin
      @(posedge clk); #1;
      if (irq_o && irq_at < 0) irq_at = n;
      if ((rst_cold_o || rst_warm_o || timeout_o) && exp_at < 0) begin
        exp_at = n; cold_s = rst_cold_o; warm_s = rst_warm_o; to_s = timeout_o; cnt_s = bus_rdata;
      end
    end
    chk("R6 R5 stage-one end edge", irq_at, e1);
    chk("R7 R5 expiry edge", exp_at, e2);
    chk("R7 cold pulse", {31'd0, cold_s}, {31'd0, cold & rsten});
    chk("R7 warm pulse", {31'd0, warm_s}, {31'd0, ~cold & rsten});
    chk("R7 timeout level at expiry", {31'd0, to_s}, {31'd0, toen});
    chk("R11 R12 count right after expiry", cnt_s, loop ? p1 : 0);
    chk("R7 timeout level held", {31'd0, timeout_o}, {31'd0, toen});
    wr(8'h18, 32'h0);
    rd(8'h0D, r);
    chk("R7 flag set", r, 32'h2);
    if (!keep) begin
      rd(8'h14, r);
      repeat (40) @(negedge clk);
      begin
        logic [31:0] r2;
        rd(8'h14, r2);
        chk("R10 stopped counter frozen", r2, r);
      end
      unlock(); wr(8'h0D, 32'h2);
      rd(8'h0D, r);
      chk("R8 keyed flag clear", r, 32'h0);
      unlock(); wr(8'h0D, 32'h1);
      #1 chk("R7 R4 timeout cleared by restart", {31'd0, timeout_o}, 32'h0);
      rd(8'h14, r);
      chk("R4 restart loads preload 1", r, p1);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired: bench hung");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] r;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    por_n = 1'b1;

    // R1 reset state
    #1 chk("R1 outputs idle", {28'd0, irq_o, rst_warm_o, rst_cold_o, timeout_o}, 32'h0);
    rd(8'h00, r); chk("R1 preload 1", r, 0);
    rd(8'h04, r); chk("R1 preload 2", r, 0);
    rd(8'h0D, r); chk("R1 flag", r, 0);
    rd(8'h10, r); chk("R1 config", r, 0);
    rd(8'h14, r); chk("R1 counter", r, 0);
    rd(8'h18, r); chk("R1 lock reg", r, 0);

    // R2 key required
    wr(8'h00, 32'd5);
    rd(8'h00, r); chk("R2 unkeyed preload ignored", r, 0);
    unlock(); wr(8'h00, 32'd5);
    rd(8'h00, r); chk("R2 keyed preload taken", r, 5);

    // R3 key spent by one write; stray byte breaks partial key
    unlock(); wr(8'h00, 32'd7); wr(8'h00, 32'd9);
    rd(8'h00, r); chk("R3 key covers one write", r, 7);
    wr(8'h0C, 32'h80); wr(8'h0C, 32'h55); wr(8'h0C, 32'h86); wr(8'h04, 32'd9);
    rd(8'h04, r); chk("R3 broken key ignored", r, 0);
    unlock(); wr(8'h04, 32'd6);
    rd(8'h04, r); chk("R3 fresh key works", r, 6);

    // directed timing cases, both tick periods and both expiry modes
    run_case(2, 3, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    run_case(3, 1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
    run_case(1, 1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);

    // random cases
    for (int i = 0; i < 8; i++) begin
      int p1, p2;
      bit lng, cold, rsten, toen, loop;
      p1 = 1 + int'($urandom % 8);
      p2 = 1 + int'($urandom % 8);
      lng = $urandom % 2; cold = $urandom % 2; rsten = $urandom % 2;
      toen = $urandom % 2; loop = $urandom % 2;
      if (!rsten && !toen) toen = 1'b1;
      run_case(p1, p2, lng, cold, rsten, toen, loop, 1'b0);
    end

    // R8 flag survives system reset, cleared by power-on
    run_case(3, 2, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
    @(negedge clk); sys_rst_n = 1'b0;
    repeat (2) @(negedge clk); sys_rst_n = 1'b1;
    rd(8'h0D, r); chk("R8 flag survives system reset", r, 32'h2);
    rd(8'h18, r); chk("R10 system reset stops counting", r, 32'h0);
    power_on();
    rd(8'h0D, r); chk("R8 power-on clears flag", r, 32'h0);

    // R9 lock
    unlock(); wr(8'h00, 32'd5);
    unlock(); wr(8'h04, 32'd5);
    wr(8'h10, 32'h0);
    wr(8'h18, 32'h3);
    rd(8'h18, r); chk("R9 lock and run set", r, 32'h3);
    unlock(); wr(8'h00, 32'h33);
    rd(8'h00, r); chk("R9 preload frozen", r, 5);
    wr(8'h10, 32'h3C);
    rd(8'h10, r); chk("R9 config frozen", r, 0);
    wr(8'h18, 32'h0);
    rd(8'h18, r); chk("R9 lock reg frozen", r, 32'h3);
    repeat (6) @(negedge clk);
    unlock(); wr(8'h0D, 32'h1);
    rd(8'h14, r); chk("R9 reload works while locked", r, 5);
    power_on();
    rd(8'h18, r); chk("R9 power-on releases lock", r, 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule